// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Aligner

This block sits between a processor's register and address path and a data memory that is one 32-bit word wide. On the load side it takes the fetched memory word and the two low address bits. It picks out the addressed byte, halfword or whole word and widens the result to 32 bits. A byte or halfword is widened by sign extension or by zero extension, as the request asks. On the store side it copies the low byte or halfword of the register operand into every lane. It also produces a 4-bit byte-write mask, so that the memory updates only the addressed lane.

Lanes are numbered big-endian: address offset 0 is the most significant byte of the memory word. The block detects requests that do not fall on their natural boundary and raises a flag for them. A flagged store produces no write mask at all. The block holds no state. Both paths are pure combinational logic, and a result is valid in the same cycle as its inputs. It has no state register, no states and no transitions.

Top module: `be_lane_unit`

## Requirements
- R1: With `acc_size` = 2'b10 (word) and `addr_lo` = 0, `ld_value` equals `rd_word` unchanged. Memory bytes 02, 04, 06, 08 at offsets 0 to 3 read as 0x02040608.
- R2: With `acc_size` = 2'b00 (byte) and `ld_zext` = 0, `ld_value` is byte lane `addr_lo` sign-extended to 32 bits. Lane k is `rd_word[31-8k -: 8]`, so offset 0 is bits 31:24. A lane holding 0xC5 loads as 0xFFFFFFC5.
- R3: With `acc_size` = 2'b00 and `ld_zext` = 1, the selected byte is zero-extended. A lane holding 0xC5 loads as 0x000000C5.
- R4: With `acc_size` = 2'b01 (halfword), offset 0 selects `rd_word[31:16]` and offset 2 selects `rd_word[15:0]`. The selected halfword is sign-extended when `ld_zext` = 0 and zero-extended when `ld_zext` = 1.
- R5: `misalign` is 1 in three cases: a halfword with `addr_lo[0]` = 1, a word with `addr_lo` not equal to 0, and the reserved size 2'b11. It is 0 for every other combination.
- R6: When `wr_req` = 1 and `misalign` = 0, `st_be` depends on the size. A byte gives one-hot `4'b1000 >> addr_lo`, so bit 3 is offset 0. A halfword gives 4'b1100 at offset 0 and 4'b0011 at offset 2. A word gives 4'b1111.
- R7: When `wr_req` = 1 and `misalign` = 0, `st_word` is set by the size. A byte gives `reg_data[7:0]` repeated in all four lanes. A halfword gives `reg_data[15:0]` repeated twice. A word gives `reg_data` unchanged.
- R8: `st_be` is 4'b0000 whenever `wr_req` = 0 or `misalign` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_lo | input | 2 | Byte offset of the access within the word |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| ld_zext | input | 1 | 1 selects zero extension for byte and halfword loads |
| wr_req | input | 1 | Access is a store |
| rd_word | input | 32 | Word fetched from memory |
| reg_data | input | 32 | Register operand to be stored |
| ld_value | output | 32 | Extended load result |
| st_word | output | 32 | Store data with the operand placed in its lanes |
| st_be | output | 4 | Byte-write mask, bit 3 = offset 0 |
| misalign | output | 1 | Access breaks its size's alignment rule |

## Verification
The assertions assume that every input is a settled, known value whenever the outputs are evaluated. Because the block is combinational, a half-driven input set would give a meaningless relation between inputs and outputs. The bench therefore changes all inputs together on the falling clock edge and compares outputs on the rising edge. The bench treats `ld_value` for misaligned accesses, and `st_word` when no store is enabled, as don't-care. It never compares those values. The stimulus still covers every size, offset, extension mode and write setting, including the reserved size.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/be_lane_align.sv
module be_lane_align
    import be_lane_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] off,
    input  acc_size_e        size,
    output logic             bad
);

    always_comb begin
        unique case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            SZ_WORD: bad = |off;
            default: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/be_lane_load.sv
module be_lane_load
    import be_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int OFF_W  = $clog2(DATA_W / LANE_W)
) (
    input  logic [DATA_W-1:0] mem_word,
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    input  logic              zext,
    output logic [DATA_W-1:0] value
);

    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int HALF_W    = 2 * LANE_W;
    localparam int NUM_HALF  = NUM_LANES / 2;

    logic [LANE_W-1:0] lane  [NUM_LANES];
    logic [HALF_W-1:0] hpair [NUM_HALF];

    // big-endian numbering: index 0 is the top of the word
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        assign lane[k] = mem_word[DATA_W-1-k*LANE_W -: LANE_W];
    end

    for (genvar j = 0; j < NUM_HALF; j++) begin : g_half
        assign hpair[j] = mem_word[DATA_W-1-j*HALF_W -: HALF_W];
    end

    logic [LANE_W-1:0] sel_b;
    logic [HALF_W-1:0] sel_h;
    logic              fill_b;
    logic              fill_h;

    always_comb begin
        sel_b  = lane[off];
        sel_h  = hpair[off[OFF_W-1:1]];
        fill_b = sel_b[LANE_W-1] & ~zext;
        fill_h = sel_h[HALF_W-1] & ~zext;
        unique case (size)
            SZ_BYTE: value = {{(DATA_W-LANE_W){fill_b}}, sel_b};
            SZ_HALF: value = {{(DATA_W-HALF_W){fill_h}}, sel_h};
            default: value = mem_word;
        endcase
    end

endmodule

// File: rtl/be_lane_store.sv
module be_lane_store
    import be_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int OFF_W  = $clog2(DATA_W / LANE_W)
) (
    input  logic [DATA_W-1:0]        src,
    input  logic [OFF_W-1:0]         off,
    input  acc_size_e                size,
    input  logic                     wr_en,
    input  logic                     blocked,
    output logic [DATA_W-1:0]        word_out,
    output logic [DATA_W/LANE_W-1:0] be_out
);

    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int HALF_W    = 2 * LANE_W;
    localparam int NUM_HALF  = NUM_LANES / 2;
    localparam logic [NUM_LANES-1:0] BYTE_TOP = {1'b1,  {(NUM_LANES-1){1'b0}}};
    localparam logic [NUM_LANES-1:0] HALF_TOP = {2'b11, {(NUM_LANES-2){1'b0}}};

    logic [DATA_W-1:0] rep_b;
    logic [DATA_W-1:0] rep_h;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_rep_b
        assign rep_b[k*LANE_W +: LANE_W] = src[LANE_W-1:0];
    end

    for (genvar j = 0; j < NUM_HALF; j++) begin : g_rep_h
        assign rep_h[j*HALF_W +: HALF_W] = src[HALF_W-1:0];
    end

    logic [NUM_LANES-1:0] mask;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                word_out = rep_b;
                mask     = BYTE_TOP >> off;
            end
            SZ_HALF: begin
                word_out = rep_h;
                mask     = HALF_TOP >> off;
            end
            default: begin
                word_out = src;
                mask     = '1;
            end
        endcase
        be_out = (wr_en && !blocked) ? mask : '0;
    end

endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
    import be_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [1:0]        addr_lo,
    input  logic [1:0]        acc_size,
    input  logic              ld_zext,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [DATA_W-1:0] reg_data,
    output logic [DATA_W-1:0] ld_value,
    output logic [DATA_W-1:0] st_word,
    output logic [3:0]        st_be,
    output logic              misalign
);

    localparam int OFF_W = 2;

    acc_size_e size_q;
    assign size_q = acc_size_e'(acc_size);

    be_lane_align #(.OFF_W(OFF_W)) align_i (
        .off  (addr_lo),
        .size (size_q),
        .bad  (misalign)
    );

    be_lane_load #(.DATA_W(DATA_W), .LANE_W(LANE_W), .OFF_W(OFF_W)) load_i (
        .mem_word (rd_word),
        .off      (addr_lo),
        .size     (size_q),
        .zext     (ld_zext),
        .value    (ld_value)
    );

    be_lane_store #(.DATA_W(DATA_W), .LANE_W(LANE_W), .OFF_W(OFF_W)) store_i (
        .src      (reg_data),
        .off      (addr_lo),
        .size     (size_q),
        .wr_en    (wr_req),
        .blocked  (misalign),
        .word_out (st_word),
        .be_out   (st_be)
    );

endmodule

// File: rtl/be_lane_unit_chk.sv
module be_lane_unit_chk #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input logic [1:0]        addr_lo,
    input logic [1:0]        acc_size,
    input logic              ld_zext,
    input logic              wr_req,
    input logic [DATA_W-1:0] rd_word,
    input logic [DATA_W-1:0] reg_data,
    input logic [DATA_W-1:0] ld_value,
    input logic [DATA_W-1:0] st_word,
    input logic [3:0]        st_be,
    input logic              misalign
);

    always_comb begin
        if (misalign || !wr_req)
            a_r8_mask_quiet: assert (st_be == 4'b0000);
        if (wr_req && !misalign)
            a_r6_mask_width: assert ($countones(st_be) ==
                ((acc_size == 2'b00) ? 1 : (acc_size == 2'b01) ? 2 : 4));
        if (acc_size == 2'b10 && addr_lo == 2'b00)
            a_r1_word_intact: assert (ld_value == rd_word);
        if (acc_size == 2'b00 && ld_zext)
            a_r3_upper_clear: assert (ld_value[DATA_W-1:LANE_W] == '0);
        if (acc_size == 2'b11)
            a_r5_reserved_flagged: assert (misalign);
        if (wr_req && !misalign && acc_size == 2'b10)
            a_r7_word_store_intact: assert (st_word == reg_data);
    end

endmodule

bind be_lane_unit be_lane_unit_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (
    .addr_lo  (addr_lo),
    .acc_size (acc_size),
    .ld_zext  (ld_zext),
    .wr_req   (wr_req),
    .rd_word  (rd_word),
    .reg_data (reg_data),
    .ld_value (ld_value),
    .st_word  (st_word),
    .st_be    (st_be),
    .misalign (misalign)
);

// File: tb/be_lane_unit_tb_top.sv
`timescale 1ns/1ps
module be_lane_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr_lo = '0;
    logic [1:0]  acc_size = '0;
    logic        ld_zext = 1'b0;
    logic        wr_req = 1'b0;
    logic [31:0] rd_word = '0;
    logic [31:0] reg_data = '0;
    logic [31:0] ld_value;
    logic [31:0] st_word;
    logic [3:0]  st_be;
    logic        misalign;

    always #10 clk = ~clk;

    be_lane_unit dut_i (
        .addr_lo  (addr_lo),
        .acc_size (acc_size),
        .ld_zext  (ld_zext),
        .wr_req   (wr_req),
        .rd_word  (rd_word),
        .reg_data (reg_data),
        .ld_value (ld_value),
        .st_word  (st_word),
        .st_be    (st_be),
        .misalign (misalign)
    );

    typedef struct {
        logic [1:0]  sz;
        logic        uns;
        logic        wr;
        logic        mis;
        logic [31:0] ld;
        logic [31:0] sw;
        logic [3:0]  be;
    } exp_t;

    exp_t q[$];
    int n_vec = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic drive(input logic [1:0] sz, input logic [1:0] off, input logic uns,
                         input logic wr, input logic [31:0] rdw, input logic [31:0] rgd);
        exp_t e;
        logic [31:0] b;
        logic [31:0] h;
        @(negedge clk);
        acc_size = sz; addr_lo = off; ld_zext = uns; wr_req = wr;
        rd_word = rdw; reg_data = rgd;
        e.sz = sz; e.uns = uns; e.wr = wr;
        e.mis = (sz == 2'b11) || (sz == 2'b01 && off[0]) || (sz == 2'b10 && off != 2'b00);
        b = rdw >> (8 * (3 - int'(off)));
        h = rdw >> (8 * (2 - int'(off)));
        case (sz)
            2'b00: begin
                e.ld = uns ? {24'h0, b[7:0]} : {{24{b[7]}}, b[7:0]};
                e.sw = {rgd[7:0], rgd[7:0], rgd[7:0], rgd[7:0]};
                e.be = 4'b1000 >> off;
            end
            2'b01: begin
                e.ld = uns ? {16'h0, h[15:0]} : {{16{h[15]}}, h[15:0]};
                e.sw = {rgd[15:0], rgd[15:0]};
                e.be = off[1] ? 4'b0011 : 4'b1100;
            end
            default: begin
                e.ld = rdw;
                e.sw = rgd;
                e.be = 4'b1111;
            end
        endcase
        if (!wr || e.mis) e.be = 4'b0000;
        q.push_back(e);
        n_vec++;
    endtask

    // monitor: compare on the rising edge, half a period after the drive
    always @(posedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            string tg;
            e = q.pop_front();
            n_chk++;
            if (misalign !== e.mis) begin
                n_fail++;
                $display("FAIL R5 misalign act=%0b exp=%0b", misalign, e.mis);
            end
            n_chk++;
            if (st_be !== e.be) begin
                n_fail++;
                $display("FAIL %s st_be act=%b exp=%b", (e.wr && !e.mis) ? "R6" : "R8", st_be, e.be);
            end
            if (!e.mis) begin
                tg = (e.sz == 2'b10) ? "R1" : (e.sz == 2'b01) ? "R4" : e.uns ? "R3" : "R2";
                n_chk++;
                if (ld_value !== e.ld) begin
                    n_fail++;
                    $display("FAIL %s ld_value act=%h exp=%h", tg, ld_value, e.ld);
                end
                if (e.wr) begin
                    n_chk++;
                    if (st_word !== e.sw) begin
                        n_fail++;
                        $display("FAIL R7 st_word act=%h exp=%h", st_word, e.sw);
                    end
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h02040608;
        pats[1] = 32'h1122C544;
        pats[2] = 32'h80FF7F01;
        pats[3] = 32'hC5A5005A;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // idle: no store, so no mask (R8)
        drive(2'b10, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
        // R1 big-endian word read
        drive(2'b10, 2'b00, 1'b0, 1'b0, 32'h02040608, 32'h0);
        // R2 / R3 byte 0xC5 at offset 2
        drive(2'b00, 2'b10, 1'b0, 1'b0, 32'h1122C544, 32'h0);
        drive(2'b00, 2'b10, 1'b1, 1'b0, 32'h1122C544, 32'h0);
        // R4 halfwords
        drive(2'b01, 2'b00, 1'b0, 1'b0, 32'h8001_7FFE, 32'h0);
        drive(2'b01, 2'b10, 1'b1, 1'b0, 32'h8001_F00D, 32'h0);
        // R5 / R8 misaligned stores
        drive(2'b10, 2'b01, 1'b0, 1'b1, 32'h0, 32'hDEADBEEF);
        drive(2'b01, 2'b11, 1'b0, 1'b1, 32'h0, 32'hDEADBEEF);
        drive(2'b11, 2'b00, 1'b0, 1'b1, 32'h0, 32'hDEADBEEF);
        // R6 / R7 aligned stores
        drive(2'b00, 2'b11, 1'b0, 1'b1, 32'h0, 32'h123456C5);
        drive(2'b01, 2'b10, 1'b0, 1'b1, 32'h0, 32'h1234ABCD);
        // sweep every size, offset, mode and write setting
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                for (int u = 0; u < 2; u++)
                    for (int w = 0; w < 2; w++)
                        for (int p = 0; p < 4; p++)
                            drive(2'(s), 2'(o), 1'(u), 1'(w), pats[p], ~pats[3-p]);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule